// File: doc/BRIEF.md
# Inter-processor doorbell interrupt register block

This block is the doorbell mailbox of one agent in a multi-processor system. Eleven agent channels share a 32-bit register word, and each channel owns one fixed bit in every register. Software rings another agent by writing ones to the trigger register, which sends a single-cycle pulse on that agent's outbound ring line. Doorbell rings from other agents arrive on asynchronous inputs. They are synchronised and edge-detected, then latched into a sticky status register that software clears by writing ones.

A mask register gates the status bits onto one interrupt output. Software cannot write the mask directly. It changes the mask through an enable alias, which clears mask bits, and a disable alias, which sets them. A read-only observation register shows the levels that the other agents report on a second set of inputs. Each channel also has an echo output that mirrors its status bit back to the agent that rang it.

The register bus is a plain 32-bit interface with single-cycle, ready-free accesses. Writes take effect at the clock edge that samples them. Reads return combinationally from the current state.

Top module: `ipi_doorbell_regs`

## Requirements
- R1: Channel k (k = 0..10) uses bit 0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27 for k = 0..10 respectively, so the valid-bit mask is 0x0F0F0301. Reserved bits always read as zero, and writing ones to them changes nothing.
- R2: Writing ones to the trigger register (offset 0x00) drives the matching `ring_out` bits high for exactly the one cycle after the write edge and low afterwards. The trigger register reads as zero.
- R3: A rising edge on `ring_in[k]` sets status bit k at the third clock edge after the input changes. A level that stays high does not set the bit again once it has been cleared.
- R4: Writing a one to a status bit (offset 0x10) clears it. Writing a zero leaves it unchanged.
- R5: If a doorbell edge sets a status bit at the same edge that a write clears it, the bit ends up set.
- R6: The mask register (offset 0x14) resets to 0x0F0F0301, and direct writes to it are ignored.
- R7: Writing ones to the enable register (offset 0x18) clears the matching mask bits. Writing ones to the disable register (offset 0x1C) sets them. Both registers read as zero.
- R8: `irq` is high exactly when some status bit is set while its mask bit is clear. It follows any change of status or mask combinationally.
- R9: Each valid bit of the observation register (offset 0x04) shows the level of `obs_in[k]` two clock edges after that input changes. Writes to the observation register are ignored.
- R10: `echo_out[k]` always equals status bit k. After reset, status, `echo_out`, `ring_out` and `irq` are all zero.
- R11: An access to any other offset, including one that is not a multiple of 4, reads as zero, and a write to it changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low reset, sampled on the clock |
| bus_sel | input | 1 | Register access valid this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational |
| ring_in | input | 11 | Asynchronous doorbell inputs, one per channel |
| obs_in | input | 11 | Asynchronous observation levels, one per channel |
| ring_out | output | 11 | Outbound single-cycle doorbell pulses |
| echo_out | output | 11 | Per-channel copy of the status bits |
| irq | output | 1 | Interrupt: any unmasked status bit set |

## Verification
Two functions can land on the same clock edge: a doorbell edge that sets a status bit, and a software write-one that clears the same bit. The bench first leaves the bit set. It then raises the doorbell input and places the clearing write on the third edge after that, which is the edge where the synchronised edge lands. It judges the outcome at the `echo_out` port, where the bit must still be set. A plain clear that follows with no edge present must then remove the bit, which shows that the survival came from the priority rule and not from a clear that had no effect.

// File: rtl/ipi_doorbell_regs.sv
module ipi_doorbell_regs #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NCH    = 11,
  parameter int SYNC_N = 2,
  parameter int unsigned CH_BIT [NCH] = '{0, 8, 9, 16, 17, 18, 19, 24, 25, 26, 27}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [NCH-1:0]    ring_in,
  input  logic [NCH-1:0]    obs_in,
  output logic [NCH-1:0]    ring_out,
  output logic [NCH-1:0]    echo_out,
  output logic              irq
);

  localparam logic [ADDR_W-1:0] OFF_TRIG = ADDR_W'('h00);
  localparam logic [ADDR_W-1:0] OFF_OBS  = ADDR_W'('h04);
  localparam logic [ADDR_W-1:0] OFF_STAT = ADDR_W'('h10);
  localparam logic [ADDR_W-1:0] OFF_MASK = ADDR_W'('h14);
  localparam logic [ADDR_W-1:0] OFF_EN   = ADDR_W'('h18);
  localparam logic [ADDR_W-1:0] OFF_DIS  = ADDR_W'('h1C);

  function automatic logic [DATA_W-1:0] spread(input logic [NCH-1:0] c);
    logic [DATA_W-1:0] w;
    w = '0;
    for (int k = 0; k < NCH; k++) w[CH_BIT[k]] = c[k];
    return w;
  endfunction

  function automatic logic [NCH-1:0] gather(input logic [DATA_W-1:0] w);
    logic [NCH-1:0] c;
    for (int k = 0; k < NCH; k++) c[k] = w[CH_BIT[k]];
    return c;
  endfunction

  localparam logic [DATA_W-1:0] VALID = spread('1);

  logic [NCH-1:0] ring_s [SYNC_N];
  logic [NCH-1:0] obs_s  [SYNC_N];
  logic [NCH-1:0] ring_prev, status, mask;

  wire            wr_acc = bus_sel & bus_wr;
  wire [NCH-1:0]  wr_ch  = gather(bus_wdata);
  wire [NCH-1:0]  rise   = ring_s[SYNC_N-1] & ~ring_prev;
  wire [NCH-1:0]  clr    = (wr_acc && bus_addr == OFF_STAT) ? wr_ch : '0;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < SYNC_N; i++) begin
        ring_s[i] <= '0;
        obs_s[i]  <= '0;
      end
      ring_prev <= '0;
    end else begin
      ring_s[0] <= ring_in;
      obs_s[0]  <= obs_in;
      for (int i = 1; i < SYNC_N; i++) begin
        ring_s[i] <= ring_s[i-1];
        obs_s[i]  <= obs_s[i-1];
      end
      ring_prev <= ring_s[SYNC_N-1];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      status   <= '0;
      mask     <= '1;
      ring_out <= '0;
    end else begin
      ring_out <= (wr_acc && bus_addr == OFF_TRIG) ? wr_ch : '0;
      status   <= (status & ~clr) | rise;
      if (wr_acc && bus_addr == OFF_EN)
        mask <= mask & ~wr_ch;
      else if (wr_acc && bus_addr == OFF_DIS)
        mask <= mask | wr_ch;
    end
  end

  always_comb begin
    case (bus_addr)
      OFF_OBS:  bus_rdata = spread(obs_s[SYNC_N-1]);
      OFF_STAT: bus_rdata = spread(status);
      OFF_MASK: bus_rdata = spread(mask);
      default:  bus_rdata = '0;
    endcase
  end

  assign echo_out = status;
  assign irq      = |(status & ~mask);

endmodule

// File: rtl/ipi_doorbell_regs_chk.sv
module ipi_doorbell_regs_chk #(
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32,
  parameter int NCH    = 11,
  parameter logic [DATA_W-1:0] VALID = '0
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_sel,
  input logic              bus_wr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_rdata,
  input logic [NCH-1:0]    ring_out,
  input logic [NCH-1:0]    echo_out,
  input logic [NCH-1:0]    mask,
  input logic              irq
);

  wire wr_trig = bus_sel && bus_wr && bus_addr == ADDR_W'('h00);
  wire wr_stat = bus_sel && bus_wr && bus_addr == ADDR_W'('h10);
  wire wr_mchg = bus_sel && bus_wr && (bus_addr == ADDR_W'('h18) || bus_addr == ADDR_W'('h1C));

  a_r1_reserved_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_sel && !bus_wr) |-> ((bus_rdata & ~VALID) == '0));

  a_r2_pulse_only_after_write: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_trig |=> (ring_out == '0));

  a_r4_status_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_stat |=> ((echo_out & $past(echo_out)) == $past(echo_out)));

  a_r7_mask_alias_only: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_mchg |=> $stable(mask));

  a_r8_no_irq_without_status: assert property (@(posedge clk) disable iff (!rst_n)
    (echo_out == '0) |-> !irq);

endmodule

bind ipi_doorbell_regs ipi_doorbell_regs_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NCH(NCH), .VALID(VALID)
) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
  .bus_addr(bus_addr), .bus_rdata(bus_rdata), .ring_out(ring_out),
  .echo_out(echo_out), .mask(mask), .irq(irq)
);

// File: tb/test_ipi_doorbell_regs.sv
module test_ipi_doorbell_regs;
  localparam int CLK_P = 10;

  logic        clk = 0;
  logic        rst_n = 0;
  logic        bus_sel = 0, bus_wr = 0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [10:0] ring_in = '0, obs_in = '0;
  logic [10:0] ring_out, echo_out;
  logic        irq;

  int checks = 0, errors = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  ipi_doorbell_regs i_ipi_doorbell_regs (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ring_in(ring_in), .obs_in(obs_in), .ring_out(ring_out),
    .echo_out(echo_out), .irq(irq)
  );

  // {trigger write data, expected ring_out pulse}
  localparam logic [42:0] TVEC [7] = '{
    {32'h0000_0001, 11'h001},
    {32'h0F0F_0301, 11'h7FF},
    {32'hF0F0_FCFE, 11'h000},
    {32'h0000_0300, 11'h006},
    {32'h0F00_0000, 11'h780},
    {32'h000F_0000, 11'h078},
    {32'h0100_0201, 11'h085}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    bus_sel = 1; bus_wr = 0; bus_addr = a;
    #1 d = bus_rdata;
    bus_sel = 0;
  endtask

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    // R10 / R6 reset state
    rd(5'h14, r); chk("R6 mask reset", r, 32'h0F0F0301);
    rd(5'h10, r); chk("R10 status reset", r, 0);
    chk("R10 echo reset", 32'(echo_out), 0);
    chk("R10 ring_out reset", 32'(ring_out), 0);
    chk("R10 irq reset", 32'(irq), 0);

    // R2 / R1 trigger vectors
    for (int i = 0; i < 7; i++) begin
      wr(5'h00, TVEC[i][42:11]);
      chk("R2 pulse high", 32'(ring_out), 32'(TVEC[i][10:0]));
      rd(5'h00, r); chk("R2 trigger reads zero", r, 0);
      @(negedge clk);
      chk("R2 pulse ends", 32'(ring_out), 0);
    end

    // R3 doorbell on channel 3 (bit 16)
    ring_in[3] = 1;
    repeat (2) @(negedge clk);
    chk("R3 not yet set", 32'(echo_out), 0);
    @(negedge clk);
    chk("R3 echo set", 32'(echo_out), 32'h008);
    rd(5'h10, r); chk("R10 status read", r, 32'h0001_0000);
    chk("R8 masked irq low", 32'(irq), 0);

    wr(5'h18, 32'h0001_0000);
    chk("R8 irq after enable", 32'(irq), 1);
    rd(5'h18, r); chk("R7 enable reads zero", r, 0);
    rd(5'h14, r); chk("R7 mask cleared", r, 32'h0F0E_0301);

    wr(5'h10, 32'h0);
    chk("R4 write zero keeps", 32'(echo_out), 32'h008);
    wr(5'h10, 32'h0001_0000);
    chk("R4 write one clears", 32'(echo_out), 0);
    chk("R8 irq after clear", 32'(irq), 0);
    repeat (5) @(negedge clk);
    chk("R3 held level no reset", 32'(echo_out), 0);
    ring_in[3] = 0;

    wr(5'h1C, 32'h0001_0000);
    rd(5'h14, r); chk("R7 disable sets mask", r, 32'h0F0F_0301);
    rd(5'h1C, r); chk("R7 disable reads zero", r, 0);

    // R5 set beats clear on the same edge (channel 1, bit 8)
    ring_in[1] = 1;
    repeat (3) @(negedge clk);
    ring_in[1] = 0;
    chk("R3 ch1 set", 32'(echo_out), 32'h002);
    repeat (3) @(negedge clk);
    ring_in[1] = 1;
    @(negedge clk);
    @(negedge clk);
    bus_sel = 1; bus_wr = 1; bus_addr = 5'h10; bus_wdata = 32'h0000_0100;
    @(negedge clk);
    bus_sel = 0; bus_wr = 0;
    chk("R5 set wins over clear", 32'(echo_out), 32'h002);
    ring_in[1] = 0;
    wr(5'h10, 32'h0000_0100);
    chk("R5 later clear works", 32'(echo_out), 0);

    // R8 second pattern on channel 7 (bit 24)
    wr(5'h18, 32'h0100_0000);
    chk("R8 enabled no status", 32'(irq), 0);
    ring_in[7] = 1;
    repeat (3) @(negedge clk);
    ring_in[7] = 0;
    chk("R8 irq on ch7", 32'(irq), 1);
    wr(5'h1C, 32'h0100_0000);
    chk("R8 irq off when masked", 32'(irq), 0);
    chk("R10 echo ch7 kept", 32'(echo_out), 32'h080);

    // R6 direct mask write ignored, R1 reserved bits
    wr(5'h14, 32'h0);
    rd(5'h14, r); chk("R6 mask write ignored", r, 32'h0F0F_0301);
    wr(5'h18, 32'hF0F0_FCFE);
    rd(5'h14, r); chk("R1 reserved enable ignored", r, 32'h0F0F_0301);
    wr(5'h10, 32'hF0F0_FCFE);
    rd(5'h10, r); chk("R1 reserved clear ignored", r, 32'h0100_0000);

    // R11 unmapped offsets
    wr(5'h08, 32'hFFFF_FFFF);
    rd(5'h08, r); chk("R11 unmapped reads zero", r, 0);
    rd(5'h14, r); chk("R11 mask untouched", r, 32'h0F0F_0301);
    chk("R11 status untouched", 32'(echo_out), 32'h080);
    rd(5'h11, r); chk("R11 misaligned reads zero", r, 0);

    // R9 observation
    obs_in = 11'h5A5;
    @(negedge clk);
    @(negedge clk);
    rd(5'h04, r); chk("R9 obs levels", r, 32'h0B04_0201);
    wr(5'h04, 32'h0);
    rd(5'h04, r); chk("R9 obs write ignored", r, 32'h0B04_0201);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule